// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Unit

This unit watches an 8-bit general-purpose input port and raises an interrupt when an enabled pin changes state. Every pin is first passed through its own polarity-inversion bit, and the resulting effective value is what the rest of the unit sees. Each pin picks one of two trigger rules. In edge mode it reports any difference from the value it had on the previous clock. In level mode it reports any difference from a programmed reference bit.

When the first trigger arrives, the unit records one triggering pin as a one-hot flag word and stores a snapshot of the whole effective port. Both stay frozen until software performs a clearing read. A configuration input decides whether the port read or the capture read is the clearing one. The interrupt pin can be driven push-pull with a selectable active level, or as an open-drain pull-down.

The serial register interface, the output latches and the pull-up control sit outside this block. Register values reach it as plain inputs, and register reads reach it as one-cycle strobes.

Top module: `gpio_change_irq`

## Requirements
- R1: After reset, the flag word and the capture word are zero, no interrupt is pending, and the interrupt pin is inactive.
- R2: An enabled pin whose control bit is 0 raises a pending interrupt on the clock edge that follows a change of its effective value. No such trigger happens on the first edge after reset.
- R3: An enabled pin whose control bit is 1 raises a pending interrupt on any clock edge where its effective value differs from its reference bit. After a clear, it raises the interrupt again on the next edge if the difference is still present.
- R4: A pin whose enable bit is 0 never sets a flag bit and never causes a capture update.
- R5: The flag word has exactly one bit set while an interrupt is pending. That bit belongs to the lowest-numbered pin that triggered on the edge that raised the interrupt.
- R6: On the edge that raises an interrupt, the capture word takes the effective port value. It keeps that value until the next interrupt is raised, even while the inputs change.
- R7: When the capture-clear select is 0, a port-read strobe clears the pending interrupt and the flag word, and a capture-read strobe has no effect. When the select is 1, the roles are swapped. A clear takes priority over a new trigger on the same edge.
- R8: The effective pin value is the input XOR its polarity-inversion bit. Both trigger rules and the capture word use this effective value.
- R9: In push-pull mode (open-drain select 0), the pin output is always driven. While an interrupt is pending it equals the active-high select; otherwise it equals the inverse of that select.
- R10: In open-drain mode, the pin output value is 0 and its drive enable equals the pending state, whatever the active-high select.
- R11: While an interrupt is pending and no clearing read occurs, the flag word does not change, even if other enabled pins trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | Synchronized pin inputs |
| polarityInv | input | 8 | Per-pin inversion of the input |
| intEnable | input | 8 | Per-pin interrupt enable |
| intControl | input | 8 | Per-pin rule: 1 compare to reference, 0 compare to previous |
| defaultVal | input | 8 | Per-pin reference value for level mode |
| clearOnCaptureRd | input | 1 | 1: capture read clears; 0: port read clears |
| irqActiveHigh | input | 1 | Push-pull active level (1 high, 0 low) |
| irqOpenDrain | input | 1 | 1 selects open-drain drive of the interrupt pin |
| rdPort | input | 1 | One-cycle strobe: port register is being read |
| rdCapture | input | 1 | One-cycle strobe: capture register is being read |
| flagReg | output | 8 | One-hot flag of the triggering pin |
| captureReg | output | 8 | Frozen snapshot of the effective port |
| irqOut | output | 1 | Interrupt pin output value |
| irqDriveEn | output | 1 | Interrupt pin output enable (0 means high-Z) |

## Verification
The bench goes after several corner cases.

- All 255 nonzero simultaneous change patterns, to confirm the lowest pin wins. A wrong priority order would flag a higher pin, and a plain copy of the change mask would set several bits.
- Every reference value in level mode, to confirm the interrupt re-fires right after a clear. An edge-only design would stay silent there.
- Input changes while an interrupt is pending. A design that reloads the capture word or the flag on every event would lose the original snapshot.
- Every inversion mask, plus both clear selects. A design that compares raw inputs would miss or invent triggers. A design that clears on the wrong read would either drop the interrupt early or never release it.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic load;   // record flag and snapshot this edge
    logic clear;  // drop the flag this edge
  } iocStrobe_t;
endpackage

// File: rtl/gpio_ioc_datapath.sv
module gpio_ioc_datapath
  import gpio_ioc_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pinIn,
  input  logic [PORT_W-1:0] polarityInv,
  input  logic [PORT_W-1:0] intEnable,
  input  logic [PORT_W-1:0] intControl,
  input  logic [PORT_W-1:0] defaultVal,
  input  iocStrobe_t        strobe,
  output logic              anyCand,
  output logic [PORT_W-1:0] flagReg,
  output logic [PORT_W-1:0] captureReg
);
  logic [PORT_W-1:0] effVal;
  logic [PORT_W-1:0] prevVal;
  logic              primed;
  logic [PORT_W-1:0] mismatch;
  logic [PORT_W-1:0] cand;
  logic [PORT_W-1:0] firstHit;
  logic              seen;

  assign effVal = pinIn ^ polarityInv;

  // per-pin trigger rule selected by the control bit
  for (genvar g = 0; g < PORT_W; g++) begin : g_rule
    assign mismatch[g] = intControl[g] ? (effVal[g] ^ defaultVal[g])
                                       : (primed & (effVal[g] ^ prevVal[g]));
  end

  assign cand    = mismatch & intEnable;
  assign anyCand = |cand;

  // lowest-numbered candidate wins
  always_comb begin
    firstHit = '0;
    seen     = 1'b0;
    for (int i = 0; i < PORT_W; i++) begin
      if (cand[i] && !seen) begin
        firstHit[i] = 1'b1;
        seen        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevVal    <= '0;
      primed     <= 1'b0;
      flagReg    <= '0;
      captureReg <= '0;
    end else begin
      prevVal <= effVal;
      primed  <= 1'b1;
      if (strobe.clear) begin
        flagReg <= '0;
      end else if (strobe.load) begin
        flagReg    <= firstHit;
        captureReg <= effVal;
      end
    end
  end
endmodule

// File: rtl/gpio_ioc_ctrl.sv
module gpio_ioc_ctrl
  import gpio_ioc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       anyCand,
  input  logic       rdPort,
  input  logic       rdCapture,
  input  logic       clearOnCaptureRd,
  input  logic       irqActiveHigh,
  input  logic       irqOpenDrain,
  output iocStrobe_t strobe,
  output logic       irqOut,
  output logic       irqDriveEn
);
  logic pending;
  logic clearHit;

  assign clearHit     = clearOnCaptureRd ? rdCapture : rdPort;
  assign strobe.clear = clearHit;
  assign strobe.load  = !clearHit && !pending && anyCand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (strobe.clear) begin
      pending <= 1'b0;
    end else if (strobe.load) begin
      pending <= 1'b1;
    end
  end

  always_comb begin
    if (irqOpenDrain) begin
      irqOut     = 1'b0;
      irqDriveEn = pending;
    end else begin
      irqOut     = pending ? irqActiveHigh : !irqActiveHigh;
      irqDriveEn = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_change_irq.sv
module gpio_change_irq
  import gpio_ioc_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pinIn,
  input  logic [PORT_W-1:0] polarityInv,
  input  logic [PORT_W-1:0] intEnable,
  input  logic [PORT_W-1:0] intControl,
  input  logic [PORT_W-1:0] defaultVal,
  input  logic              clearOnCaptureRd,
  input  logic              irqActiveHigh,
  input  logic              irqOpenDrain,
  input  logic              rdPort,
  input  logic              rdCapture,
  output logic [PORT_W-1:0] flagReg,
  output logic [PORT_W-1:0] captureReg,
  output logic              irqOut,
  output logic              irqDriveEn
);
  iocStrobe_t strobe;
  logic       anyCand;

  gpio_ioc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .anyCand(anyCand),
    .rdPort(rdPort), .rdCapture(rdCapture),
    .clearOnCaptureRd(clearOnCaptureRd), .irqActiveHigh(irqActiveHigh),
    .irqOpenDrain(irqOpenDrain), .strobe(strobe),
    .irqOut(irqOut), .irqDriveEn(irqDriveEn)
  );

  gpio_ioc_datapath #(.PORT_W(PORT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .polarityInv(polarityInv),
    .intEnable(intEnable), .intControl(intControl), .defaultVal(defaultVal),
    .strobe(strobe), .anyCand(anyCand),
    .flagReg(flagReg), .captureReg(captureReg)
  );
endmodule

// File: rtl/gpio_change_irq_chk.sv
module gpio_change_irq_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PORT_W-1:0] pinIn,
  input logic [PORT_W-1:0] polarityInv,
  input logic [PORT_W-1:0] intEnable,
  input logic              clearOnCaptureRd,
  input logic              irqActiveHigh,
  input logic              irqOpenDrain,
  input logic              rdPort,
  input logic              rdCapture,
  input logic [PORT_W-1:0] flagReg,
  input logic [PORT_W-1:0] captureReg,
  input logic              irqOut,
  input logic              irqDriveEn
);
  logic clrRd;
  assign clrRd = clearOnCaptureRd ? rdCapture : rdPort;

  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flagReg)); // R5

  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (flagReg != '0) |=> $stable(captureReg)); // R6

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flagReg != '0 && !clrRd) |=> $stable(flagReg)); // R11

  AST_CLEAR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clrRd) |=> (flagReg == '0)); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flagReg == '0) |=> ((flagReg & ~$past(intEnable)) == '0)); // R4

  AST_SNAPSHOT_EFF: assert property (@(posedge clk) disable iff (!rst_n)
    (flagReg == '0) |=> (flagReg == '0 || captureReg == $past(pinIn ^ polarityInv))); // R8

  AST_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    irqOpenDrain |-> (irqOut == 1'b0 && irqDriveEn == (flagReg != '0))); // R10

  AST_PUSH_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    !irqOpenDrain |-> (irqDriveEn && irqOut == ((flagReg != '0) ? irqActiveHigh : !irqActiveHigh))); // R9
endmodule

bind gpio_change_irq gpio_change_irq_chk #(.PORT_W(PORT_W)) chk (
  .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .polarityInv(polarityInv),
  .intEnable(intEnable), .clearOnCaptureRd(clearOnCaptureRd),
  .irqActiveHigh(irqActiveHigh), .irqOpenDrain(irqOpenDrain),
  .rdPort(rdPort), .rdCapture(rdCapture), .flagReg(flagReg),
  .captureReg(captureReg), .irqOut(irqOut), .irqDriveEn(irqDriveEn)
);

// File: tb/gpio_change_irq_test.sv
module gpio_change_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pinIn = '0, polarityInv = '0, intEnable = '0, intControl = '0, defaultVal = '0;
  logic       clearOnCaptureRd = 1'b0, irqActiveHigh = 1'b0, irqOpenDrain = 1'b0;
  logic       rdPort = 1'b0, rdCapture = 1'b0;
  logic [7:0] flagReg, captureReg;
  logic       irqOut, irqDriveEn;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // reference state
  logic       mPend = 0, mPrimed = 0;
  logic [7:0] mFlag = 0, mCap = 0, mPrev = 0;

  always #2 clk = ~clk;

  gpio_change_irq uut (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .polarityInv(polarityInv),
    .intEnable(intEnable), .intControl(intControl), .defaultVal(defaultVal),
    .clearOnCaptureRd(clearOnCaptureRd), .irqActiveHigh(irqActiveHigh),
    .irqOpenDrain(irqOpenDrain), .rdPort(rdPort), .rdCapture(rdCapture),
    .flagReg(flagReg), .captureReg(captureReg), .irqOut(irqOut), .irqDriveEn(irqDriveEn)
  );

  task automatic compareNow(input string tag);
    logic expOut, expDrv;
    if (irqOpenDrain) begin
      expOut = 1'b0; expDrv = mPend;
    end else begin
      expDrv = 1'b1; expOut = mPend ? irqActiveHigh : ~irqActiveHigh;
    end
    vectors++;
    if (flagReg !== mFlag || captureReg !== mCap || irqOut !== expOut || irqDriveEn !== expDrv) begin
      misses++;
      $display("FAIL %s: flag=%h cap=%h out=%b drv=%b expected flag=%h cap=%h out=%b drv=%b",
               tag, flagReg, captureReg, irqOut, irqDriveEn, mFlag, mCap, expOut, expDrv);
    end
  endtask

  // called just after a falling edge with inputs already set
  task automatic stepCheck(input string tag);
    logic [7:0] eff, lvl, edg, cand;
    logic clr;
    eff  = pinIn ^ polarityInv;
    lvl  = intControl & (eff ^ defaultVal);
    edg  = mPrimed ? (~intControl & (eff ^ mPrev)) : 8'h00;
    cand = (lvl | edg) & intEnable;
    clr  = clearOnCaptureRd ? rdCapture : rdPort;
    if (clr) begin
      mPend = 0; mFlag = 0;
    end else if (!mPend && cand != 0) begin
      mPend = 1; mFlag = cand & (8'd0 - cand); mCap = eff;
    end
    mPrev = eff; mPrimed = 1;
    @(posedge clk); #1;
    compareNow(tag);
    @(negedge clk);
  endtask

  task automatic clearRead(input string tag);
    if (clearOnCaptureRd) rdCapture = 1'b1; else rdPort = 1'b1;
    stepCheck(tag);
    rdCapture = 1'b0; rdPort = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 compareNow("R1 reset state");

    // R2: edge mode, each pin alone
    intEnable = 8'hFF; intControl = 8'h00;
    stepCheck("R2 settle");
    for (int i = 0; i < 8; i++) begin
      pinIn = pinIn ^ (8'd1 << i);
      stepCheck("R2 single toggle");
      stepCheck("R11 hold");
      clearRead("R7 port clear");
    end

    // R4: disabled pin toggles
    for (int i = 0; i < 8; i++) begin
      intEnable = ~(8'd1 << i);
      pinIn = pinIn ^ (8'd1 << i);
      stepCheck("R4 disabled toggle");
    end
    intEnable = 8'hFF;

    // R5: every simultaneous change pattern
    pinIn = 8'h00; stepCheck("R5 base"); clearRead("R5 base clear");
    for (int p = 1; p < 256; p++) begin
      pinIn = p[7:0];
      stepCheck("R5 lowest wins");
      clearRead("R5 clear");
      pinIn = 8'h00;
      stepCheck("R5 return");
      clearRead("R5 clear");
    end

    // R6/R11: inputs move while pending
    pinIn = 8'h10; stepCheck("R6 trigger");
    for (int k = 0; k < 16; k++) begin
      pinIn = 8'(k * 37);
      stepCheck("R6 frozen snapshot");
    end
    clearRead("R7 clear");

    // R3: level mode over all reference values
    intControl = 8'hFF; pinIn = 8'hA5;
    for (int d = 0; d < 256; d++) begin
      defaultVal = d[7:0];
      stepCheck("R3 reference compare");
      clearRead("R3 clear");
      stepCheck("R3 refire");
      clearRead("R3 clear");
    end
    defaultVal = 8'hA5; stepCheck("R3 match"); clearRead("R3 idle");

    // R7: capture read as the clearing read
    intControl = 8'h00; clearOnCaptureRd = 1'b1;
    for (int i = 0; i < 8; i++) begin
      pinIn = pinIn ^ (8'd1 << i);
      stepCheck("R7 trigger");
      rdPort = 1'b1; stepCheck("R7 port read ignored"); rdPort = 1'b0;
      rdCapture = 1'b1; stepCheck("R7 capture clears"); rdCapture = 1'b0;
    end
    clearOnCaptureRd = 1'b0;
    pinIn = pinIn ^ 8'h01; stepCheck("R7 trigger");
    rdCapture = 1'b1; stepCheck("R7 capture read ignored"); rdCapture = 1'b0;
    clearRead("R7 port clears");

    // R8: every inversion mask
    for (int v = 0; v < 256; v++) begin
      polarityInv = v[7:0];
      stepCheck("R8 inversion");
      clearRead("R8 clear");
    end

    // R9/R10: pin drive modes
    for (int m = 0; m < 4; m++) begin
      irqOpenDrain  = m[1];
      irqActiveHigh = m[0];
      stepCheck(m[1] ? "R10 idle" : "R9 idle");
      pinIn = pinIn ^ 8'h80;
      stepCheck(m[1] ? "R10 asserted" : "R9 asserted");
      stepCheck(m[1] ? "R10 held" : "R9 held");
      clearRead(m[1] ? "R10 released" : "R9 released");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule